// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects three interrupt sources for a small 8-bit processor core. The sources are an edge on an external pin, a rollover strobe from an 8-bit timer, and a change on four port input pins. It keeps one control register that holds a sticky flag and an enable for each source, plus a global enable. From that register it produces two outputs. A wake request tells the core to leave sleep. A vector request tells the core to start its branch to the fixed interrupt address.

The core supplies a four-phase instruction timing code. The combined interrupt condition is sampled only on the clock edge where that code reads the first phase. Wake depends only on the per-source enables. The global enable decides separately whether a vector branch follows. When the branch is taken, the block clears the global enable so that interrupts do not nest. A return strobe sets it again. Software reads and writes the control register through a plain port. A read strobe on the port refreshes the latch that port changes are compared against.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `reg_rdata`, `wake_req` and `vec_req` are all 0.
- R2: The external pin goes through a two-stage synchronizer. If `edge_rising`=1, a 0-to-1 change sets flag bit 1. If `edge_rising`=0, a 1-to-0 change sets it. A level first sampled at clock edge t shows in the flag after edge t+2. A change in the other direction sets nothing.
- R3: A `tmr_wrap` pulse sets flag bit 2 at the next clock edge.
- R4: Flag bit 0 is set on any edge where `port_pins` differs from the port latch. `port_rd` loads the latch from `port_pins`. After that read, pins that match the latch set nothing.
- R5: Only a register write clears a flag. When a write clears a flag on the same edge that hardware sets it, the set wins.
- R6: The register layout is: bit 7 global enable, bit 6 reads 0, bit 5 timer enable, bit 4 external enable, bit 3 port enable, bits 2..0 the flags. `reg_we` loads bits 7 and 5..0 from `reg_wdata`.
- R7: On each first-phase edge (`q_phase`=0), `wake_req` is loaded with `sleeping` AND (any flag whose enable is set). It is independent of the global enable.
- R8: On a first-phase edge where the global enable is 1 and an enabled flag is set, `vec_req` goes high for exactly one cycle and the global enable is cleared on that same edge.
- R9: `ret_strobe` sets the global enable, overriding a write in the same cycle. A vector branch taken on the same edge overrides it.
- R10: `wake_req` and `vec_req` change only after first-phase edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_phase | input | 2 | Instruction phase code, 0 = first phase |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| edge_rising | input | 1 | 1 = rising edge active, 0 = falling |
| tmr_wrap | input | 1 | Timer rollover strobe |
| port_pins | input | 4 | Upper port input pins |
| port_rd | input | 1 | Port read strobe, refreshes the latch |
| sleeping | input | 1 | Core is in sleep |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| wake_req | output | 1 | Wake request |
| vec_req | output | 1 | One-cycle vector branch request |

## Verification
The assertions assume that `q_phase` advances by one each clock, so two first-phase edges never follow each other. The phase-origin checks and the one-cycle pulse checks rely on that. The bench drives the phase from a free-running counter, and drives every other input just after the falling edge so it stays stable across the rising edge. The external pin is held low through reset, which keeps the synchronizer from reporting a false first edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 8;
  localparam int SRC_N   = 3;
  localparam int BIT_GIE = 7;
  localparam int EN_LSB  = 3;
  localparam int FLG_LSB = 0;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rising,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  always_comb begin
    if (rising) edge_hit = sync_q[STAGES-1] & ~prev_q;
    else        edge_hit = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         rd,
  output logic         changed
);
  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (rd) latch_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign changed = |(pins ^ latch_q);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             ret,
  input  logic             take,
  output logic [SRC_N-1:0] flags,
  output logic [SRC_N-1:0] enables,
  output logic             gie
);
  logic [SRC_N-1:0] flags_d, en_d;
  logic             gie_d;

  always_comb begin
    flags_d = flags;
    en_d    = enables;
    gie_d   = gie;
    if (we) begin
      flags_d = wdata[FLG_LSB +: SRC_N];
      en_d    = wdata[EN_LSB +: SRC_N];
      gie_d   = wdata[BIT_GIE];
    end
    flags_d = flags_d | set;
    if (ret)  gie_d = 1'b1;
    if (take) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
      gie     <= 1'b0;
    end else begin
      flags   <= flags_d;
      enables <= en_d;
      gie     <= gie_d;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        q_phase,
  input  logic              ext_pin,
  input  logic              edge_rising,
  input  logic              tmr_wrap,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              port_rd,
  input  logic              sleeping,
  input  logic              ret_strobe,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wake_req,
  output logic              vec_req
);
  logic             ext_hit, port_hit;
  logic [SRC_N-1:0] set_vec, flags, enables;
  logic             gie, pend, q1_en, take;
  logic             wake_d, vec_d;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .rising(edge_rising), .edge_hit(ext_hit)
  );

  irq_port_change #(.W(PORT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .pins(port_pins),
    .rd(port_rd), .changed(port_hit)
  );

  assign set_vec = {tmr_wrap, ext_hit, port_hit};

  irq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .set(set_vec),
    .we(reg_we), .wdata(reg_wdata), .ret(ret_strobe),
    .take(take), .flags(flags), .enables(enables), .gie(gie)
  );

  assign q1_en = (phase_t'(q_phase) == PH_Q1);
  assign pend  = |(flags & enables);
  assign take  = q1_en & gie & pend;

  always_comb begin
    wake_d = wake_req;
    if (q1_en) wake_d = sleeping & pend;
    vec_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_req <= 1'b0;
      vec_req  <= 1'b0;
    end else begin
      wake_req <= wake_d;
      vec_req  <= vec_d;
    end
  end

  assign reg_rdata = {gie, 1'b0, enables, flags};
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] q_phase,
  input logic       tmr_wrap,
  input logic       ret_strobe,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       wake_req,
  input logic       vec_req
);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> ((reg_rdata[2:0] & $past(reg_rdata[2:0])) == $past(reg_rdata[2:0])));

  assert_tmr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> reg_rdata[2]);

  assert_vec_clears_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (!reg_rdata[7] && $past(reg_rdata[7])));

  assert_vec_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req);

  assert_ret_sets_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> (reg_rdata[7] || vec_req));

  assert_vec_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_req) |-> ($past(q_phase) == 2'd0));

  assert_wake_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wake_req) |-> ($past(q_phase) == 2'd0));

  assert_bit6_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .tmr_wrap(tmr_wrap),
  .ret_strobe(ret_strobe), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .wake_req(wake_req), .vec_req(vec_req)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] q_phase = 2'd0;
  logic       ext_pin = 1'b0, edge_rising = 1'b1, tmr_wrap = 1'b0;
  logic [3:0] port_pins = 4'd0;
  logic       port_rd = 1'b0, sleeping = 1'b0, ret_strobe = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wake_req, vec_req;

  int checks = 0, failures = 0;
  bit armed = 0, finished = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .ext_pin(ext_pin),
    .edge_rising(edge_rising), .tmr_wrap(tmr_wrap), .port_pins(port_pins),
    .port_rd(port_rd), .sleeping(sleeping), .ret_strobe(ret_strobe),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_req(wake_req), .vec_req(vec_req)
  );

  // reference model state
  bit [2:0] m_flags, m_en;
  bit       m_gie, m_wake, m_vec;
  bit [3:0] m_latch;
  bit       h0, h1, h2;

  always @(posedge clk) begin
    bit pend, take, edge_seen;
    bit [2:0] nf;
    if (!rst_n) begin
      m_flags = 0; m_en = 0; m_gie = 0; m_wake = 0; m_vec = 0;
      m_latch = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      pend = (m_flags & m_en) != 0;
      take = (q_phase == 2'd0) && m_gie && pend;
      edge_seen = edge_rising ? (h1 && !h2) : (!h1 && h2);
      nf = reg_we ? reg_wdata[2:0] : m_flags;
      nf[2] = nf[2] | tmr_wrap;
      nf[1] = nf[1] | edge_seen;
      nf[0] = nf[0] | (port_pins != m_latch);
      if (port_rd) m_latch = port_pins;
      h2 = h1; h1 = h0; h0 = ext_pin;
      if (reg_we) begin m_en = reg_wdata[5:3]; m_gie = reg_wdata[7]; end
      if (ret_strobe) m_gie = 1;
      if (take) m_gie = 0;
      if (q_phase == 2'd0) m_wake = sleeping && pend;
      m_vec = take;
      m_flags = nf;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && armed && !finished) begin
      check("R4 port flag", {7'd0, reg_rdata[0]}, {7'd0, m_flags[0]});
      check("R2 ext flag", {7'd0, reg_rdata[1]}, {7'd0, m_flags[1]});
      check("R3 tmr flag", {7'd0, reg_rdata[2]}, {7'd0, m_flags[2]});
      check("R6 ctrl bits", {reg_rdata[7:3], 3'd0}, {m_gie, 1'b0, m_en, 3'd0});
      check("R7 R10 wake", {7'd0, wake_req}, {7'd0, m_wake});
      check("R8 R10 vec", {7'd0, vec_req}, {7'd0, m_vec});
    end
  end

  always @(negedge clk) if (rst_n) q_phase <= q_phase + 2'd1;

  task automatic wr(logic [7:0] d);
    reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    int pulses;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset outs", {6'd0, wake_req, vec_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {reg_rdata[7:1], wake_req | vec_req}, 8'h00);
    armed = 1;

    // R6 layout and R2 rising edge with latency
    wr(8'h78);
    check("R6 bit6 masked", reg_rdata, 8'h38);
    ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not yet", {7'd0, reg_rdata[1]}, 8'h00);
    @(negedge clk);
    check("R2 rising set", {7'd0, reg_rdata[1]}, 8'h01);

    // R5 clear and hardware set on the same edge
    reg_wdata = 8'h38; reg_we = 1'b1; tmr_wrap = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tmr_wrap = 1'b0;
    check("R5 set wins", reg_rdata, 8'h3C);
    wr(8'h38);
    check("R5 write clears", reg_rdata, 8'h38);

    // R7 wake without global enable
    sleeping = 1'b1; tmr_wrap = 1'b1;
    @(negedge clk); tmr_wrap = 1'b0;
    pulses = 0;
    repeat (5) begin @(negedge clk); pulses += vec_req; end
    check("R7 wake set", {7'd0, wake_req}, 8'h01);
    check("R7 no vector", pulses[7:0], 8'h00);
    wr(8'h04);
    repeat (5) @(negedge clk);
    check("R7 wake drops", {7'd0, wake_req}, 8'h00);

    // R8 vector pulse clears global enable
    sleeping = 1'b0;
    wr(8'hA4);
    pulses = 0;
    repeat (5) begin @(negedge clk); pulses += vec_req; end
    check("R8 one pulse", pulses[7:0], 8'h01);
    check("R8 gie cleared", {7'd0, reg_rdata[7]}, 8'h00);

    // R9 return strobe
    ret_strobe = 1'b1;
    @(negedge clk); ret_strobe = 1'b0;
    check("R9 gie set", {7'd0, reg_rdata[7]}, 8'h01);
    repeat (5) @(negedge clk);
    wr(8'h00);

    // R4 port change and latch refresh
    port_pins = 4'b0001;
    @(negedge clk);
    check("R4 change set", {7'd0, reg_rdata[0]}, 8'h01);
    port_rd = 1'b1;
    @(negedge clk); port_rd = 1'b0;
    wr(8'h00);
    @(negedge clk);
    check("R4 matched latch", {7'd0, reg_rdata[0]}, 8'h00);

    // R2 falling polarity
    edge_rising = 1'b0; ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 falling set", {7'd0, reg_rdata[1]}, 8'h01);
    wr(8'h00);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 rising ignored", {7'd0, reg_rdata[1]}, 8'h00);

    // mixed stimulus against the model
    lfsr = 16'hACE1;
    repeat (400) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reg_we = (lfsr[3:0] == 4'd5);
      reg_wdata = {lfsr[15:8]};
      tmr_wrap = (lfsr[6:4] == 3'd2);
      ret_strobe = (lfsr[9:6] == 4'd9);
      ext_pin = lfsr[11];
      edge_rising = lfsr[14] & lfsr[2];
      sleeping = lfsr[12];
      port_rd = lfsr[1];
      if (lfsr[7:5] == 3'd0) port_pins = lfsr[13:10];
    end
    reg_we = 0; tmr_wrap = 0; ret_strobe = 0; port_rd = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule